// File: doc/BRIEF.md
# Row Hit Sub-Pattern Logger

This block sits in the control column beside one row of pixels. It takes 48 comparator hit flags and a time code. On each sample strobe it captures the flags and removes the pixels that a serially loaded mask has switched off. It then divides the row into eight groups of six neighbouring pixels.

A group counts only when two or more of its pixels fired. Each such group becomes one stored word: the time code, the group number and the six-bit group pattern. These words go into a small circular bank, one per clock, during the nine-clock period that follows the strobe. A column readout sequencer drains the bank oldest-first through a valid/ready port. When the bank has no room, new words are discarded and a sticky flag records the loss.

Top module: `row_pattern_logger`

## Requirements
- R1: After a synchronous active-low reset, `rd_valid` and `overflow` are 0. The mask is all zero, so every pixel is enabled.
- R2: A group k (pixels 6k to 6k+5) with two or more masked-in hits is stored as one word `rd_data = {time_code, k[2:0], pattern}`. In that word, pattern bit j is pixel 6k+j, bits [5:0] hold the pattern, bits [8:6] hold the group ID and the time code occupies the upper bits.
- R3: A group with zero or one masked-in hit produces no word.
- R4: Words from one sample are written one per clock in ascending group ID. The first is written on the first clock edge after the edge that captured the strobe, so with an empty bank `rd_valid` rises one cycle after the capture edge.
- R5: While `mask_load` is 1, `mask_din` shifts into the mask one bit per clock, most significant pixel (47) first. Mask bit 1 suppresses that pixel. While `mask_load` is 0, `mask_din` has no effect.
- R6: `rd_valid` is 1 exactly while the bank holds a word. A word leaves on a clock edge where `rd_valid` and `rd_ready` are both 1. Words leave in the order they were written. While `rd_ready` is 0, `rd_valid` and `rd_data` hold.
- R7: The bank holds DEPTH words (default 19). A qualifying group that finds the bank full is dropped and sets `overflow`. `overflow` stays 1 until a cycle with `ovf_clr` high and no new drop.
- R8: The time code stored is the value present at the capture edge. Later changes do not alter it.
- R9: `ext_trig` starts a sample exactly as `sample_tick` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock, nine cycles per sample period |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_flags | input | 48 | Comparator hit flag per pixel |
| time_code | input | 8 | Time stamp attached to the words of a sample |
| sample_tick | input | 1 | Periodic sample strobe |
| ext_trig | input | 1 | External trigger strobe |
| mask_load | input | 1 | Enables serial mask shifting |
| mask_din | input | 1 | Serial mask bit, pixel 47 first |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_ready | input | 1 | Readout sequencer accepts a word |
| rd_valid | output | 1 | Bank holds at least one word |
| rd_data | output | 17 | Oldest word: time code, group ID, pattern |
| overflow | output | 1 | Sticky: a qualifying group was dropped |

## Verification
The bench counts edges from the capture edge for every result:
- The first word becomes visible one cycle after the capture edge.
- The remaining words follow one per cycle and are all written within eight cycles.
- `overflow` is set on the edge that would have stored the first dropped word.

Inputs are driven on falling edges and `rd_ready` just after rising edges. Outputs are sampled on falling edges, so each check reads a settled state.

The monitor compares every handshaken word against a scoreboard queue. The queue is filled from the flags, the mask and the time code present at each strobe. One dedicated sequence samples `rd_valid` at exactly the capture-plus-one and capture-plus-two falling edges to pin the write latency.

// File: rtl/rpl_pkg.sv
// Package: shared defaults and a helper for the row logger.
// Assumes callers zero-extend group vectors to 32 bits.
package rpl_pkg;
    localparam int DEF_PIXELS = 48;
    localparam int DEF_GROUP  = 6;
    localparam int DEF_TC_W   = 8;
    localparam int DEF_DEPTH  = 19;

    // True when at least two bits of v are set.
    function automatic logic multi_hit(input logic [31:0] v);
        return |(v & (v - 32'd1));
    endfunction
endpackage

// File: rtl/rpl_mask_sr.sv
// Module: serial pixel mask shift register.
// Shifts mask_din in at bit 0 while load is high, so the first bit shifted
// ends at the top pixel after PIXELS shifts. Holds otherwise.
module rpl_mask_sr #(
    parameter int PIXELS = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              din,
    output logic [PIXELS-1:0] mask
);
    logic [PIXELS-1:0] mask_q;

    // Shift in one bit per clock while loading, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= '0;
        else if (load) mask_q <= {mask_q[PIXELS-2:0], din};
    end

    assign mask = mask_q;

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mask_q));
endmodule

// File: rtl/rpl_group_scan.sv
// Module: captures a masked sample and emits qualifying groups.
// On start it latches the masked flags, the time code and the set of groups
// holding two or more hits. It then emits one write per clock, lowest group
// first. Assumes strobes are at least GROUPS+1 cycles apart; a new strobe
// replaces any unfinished scan.
module rpl_group_scan #(
    parameter int PIXELS = 48,
    parameter int GROUP  = 6,
    parameter int TC_W   = 8,
    localparam int GROUPS = PIXELS / GROUP,
    localparam int ID_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PIXELS-1:0] flags,
    input  logic [PIXELS-1:0] mask,
    input  logic [TC_W-1:0]   tc_in,
    output logic              wr_en,
    output logic [ID_W-1:0]   wr_id,
    output logic [GROUP-1:0]  wr_pat,
    output logic [TC_W-1:0]   wr_tc
);
    logic [PIXELS-1:0] masked;
    logic [GROUPS-1:0] qual;
    logic [PIXELS-1:0] pat_q;
    logic [GROUPS-1:0] pend_q;
    logic [TC_W-1:0]   tc_q;
    logic [ID_W-1:0]   sel;
    logic [GROUPS-1:0] sel_oh;

    assign masked = flags & ~mask;

    // One coincidence detector per group.
    for (genvar g = 0; g < GROUPS; g++) begin : g_qual
        assign qual[g] = rpl_pkg::multi_hit(32'(masked[g*GROUP +: GROUP]));
    end

    // Pick the lowest pending group.
    always_comb begin
        sel    = '0;
        sel_oh = '0;
        for (int i = GROUPS - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                sel    = ID_W'(i);
                sel_oh = GROUPS'(1) << i;
            end
        end
    end

    // Capture a sample on start, otherwise retire one pending group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q  <= '0;
            pend_q <= '0;
            tc_q   <= '0;
        end else if (start) begin
            pat_q  <= masked;
            pend_q <= qual;
            tc_q   <= tc_in;
        end else begin
            pend_q <= pend_q & ~sel_oh;
        end
    end

    assign wr_en  = |pend_q;
    assign wr_id  = sel;
    assign wr_pat = pat_q[sel*GROUP +: GROUP];
    assign wr_tc  = tc_q;

    // R3
    multi_hit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $countones(wr_pat) >= 2);
    // R4
    ascending_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !start) |=> (!wr_en || wr_id > $past(wr_id)));
endmodule

// File: rtl/rpl_bank.sv
// Module: circular register bank with valid/ready read port.
// Holds DEPTH words. A write that finds the bank full is dropped and sets a
// sticky overflow flag; a drop in the same cycle as a clear wins.
module rpl_bank #(
    parameter int W     = 17,
    parameter int DEPTH = 19,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_ready,
    input  logic         ovf_clr,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    output logic         overflow
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             full, wr_acc, rd_acc;

    assign full     = (cnt_q == CNT_W'(DEPTH));
    assign wr_acc   = wr_en && !full;
    assign rd_valid = (cnt_q != '0);
    assign rd_acc   = rd_valid && rd_ready;
    assign rd_data  = mem[rp_q];
    assign overflow = ovf_q;

    // Store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_acc) mem[wp_q] <= wr_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_acc) wp_q <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (rd_acc) rp_q <= (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q + CNT_W'(wr_acc) - CNT_W'(rd_acc);
        end
    end

    // Sticky drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n)              ovf_q <= 1'b0;
        else if (wr_en && full)  ovf_q <= 1'b1;
        else if (ovf_clr)        ovf_q <= 1'b0;
    end

    // R7
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    // R7
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow);
    // R6
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/row_pattern_logger.sv
// Module: top of the row hit sub-pattern logger.
// Joins the mask register, the group scanner and the register bank. Either
// strobe starts a sample. Words are {time code, group ID, pattern}.
module row_pattern_logger #(
    parameter int PIXELS = rpl_pkg::DEF_PIXELS,
    parameter int GROUP  = rpl_pkg::DEF_GROUP,
    parameter int TC_W   = rpl_pkg::DEF_TC_W,
    parameter int DEPTH  = rpl_pkg::DEF_DEPTH,
    localparam int GROUPS = PIXELS / GROUP,
    localparam int ID_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int WORD_W = TC_W + ID_W + GROUP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIXELS-1:0] hit_flags,
    input  logic [TC_W-1:0]   time_code,
    input  logic              sample_tick,
    input  logic              ext_trig,
    input  logic              mask_load,
    input  logic              mask_din,
    input  logic              ovf_clr,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              overflow
);
    logic [PIXELS-1:0] mask;
    logic              start;
    logic              wr_en;
    logic [ID_W-1:0]   wr_id;
    logic [GROUP-1:0]  wr_pat;
    logic [TC_W-1:0]   wr_tc;

    assign start = sample_tick | ext_trig;

    rpl_mask_sr #(.PIXELS(PIXELS)) u_mask (
        .clk(clk), .rst_n(rst_n), .load(mask_load), .din(mask_din), .mask(mask)
    );

    rpl_group_scan #(.PIXELS(PIXELS), .GROUP(GROUP), .TC_W(TC_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .start(start), .flags(hit_flags),
        .mask(mask), .tc_in(time_code), .wr_en(wr_en), .wr_id(wr_id),
        .wr_pat(wr_pat), .wr_tc(wr_tc)
    );

    rpl_bank #(.W(WORD_W), .DEPTH(DEPTH)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_data({wr_tc, wr_id, wr_pat}), .rd_ready(rd_ready),
        .ovf_clr(ovf_clr), .rd_valid(rd_valid), .rd_data(rd_data),
        .overflow(overflow)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && !overflow));
endmodule

// File: tb/row_pattern_logger_tb_top.sv
// Scoreboard bench: the driver queues expected words per sample, the monitor
// compares every handshaken word on falling edges.
module row_pattern_logger_tb_top;
    localparam int DEPTH = 19;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [47:0] hit_flags;
    logic [7:0]  time_code;
    logic        sample_tick, ext_trig, mask_load, mask_din, ovf_clr, rd_ready;
    logic        rd_valid, overflow;
    logic [16:0] rd_data;

    int checks = 0;
    int failures = 0;
    logic [47:0] mask_model = '0;
    logic [16:0] expq [$];

    always #10 clk = ~clk;

    row_pattern_logger dut_i (
        .clk(clk), .rst_n(rst_n), .hit_flags(hit_flags), .time_code(time_code),
        .sample_tick(sample_tick), .ext_trig(ext_trig), .mask_load(mask_load),
        .mask_din(mask_din), .ovf_clr(ovf_clr), .rd_ready(rd_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // Monitor: each accepted word must match the scoreboard head (R2 R6 R8).
    always @(negedge clk) begin
        if (rst_n && rd_valid && rd_ready) begin
            if (expq.size() == 0) begin
                check(1'b0, "R3 unexpected word", 32'(rd_data), 32'h0);
            end else begin
                check(rd_data == expq[0], "R2 R6 R8 word", 32'(rd_data), 32'(expq[0]));
                void'(expq.pop_front());
            end
        end
    end

    task automatic set_ready(input logic v);
        @(posedge clk); #1 rd_ready = v;
    endtask

    task automatic load_mask(input logic [47:0] m);
        for (int i = 47; i >= 0; i--) begin
            @(negedge clk); mask_load = 1'b1; mask_din = m[i];
        end
        @(negedge clk); mask_load = 1'b0; mask_din = 1'b0;
        mask_model = m;
    endtask

    // Drive one strobe; queue the words the requirements predict.
    task automatic strobe(input logic [47:0] f, input logic [7:0] tc, input bit trig);
        logic [47:0] mf;
        @(negedge clk);
        hit_flags = f; time_code = tc;
        if (trig) ext_trig = 1'b1; else sample_tick = 1'b1;
        mf = f & ~mask_model;
        for (int k = 0; k < 8; k++) begin
            if ($countones(mf[k*6 +: 6]) > 1 && expq.size() < DEPTH)
                expq.push_back({tc, 3'(k), mf[k*6 +: 6]});
        end
        @(negedge clk);
        sample_tick = 1'b0; ext_trig = 1'b0;
        time_code = ~tc; hit_flags = ~f;
    endtask

    task automatic sample(input logic [47:0] f, input logic [7:0] tc, input bit trig);
        strobe(f, tc, trig);
        repeat (10) @(negedge clk);
    endtask

    task automatic drain_check(input string req);
        repeat (25) @(negedge clk);
        check(expq.size() == 0, req, 32'(expq.size()), 32'd0);
        check(rd_valid == 1'b0, req, 32'(rd_valid), 32'd0);
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; hit_flags = '0; time_code = '0; sample_tick = 0; ext_trig = 0;
        mask_load = 0; mask_din = 0; ovf_clr = 0; rd_ready = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rd_valid == 1'b0, "R1 rd_valid", 32'(rd_valid), 32'd0);
        check(overflow == 1'b0, "R1 overflow", 32'(overflow), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: all-zero mask keeps a two-hit group visible
        set_ready(1'b1);
        sample(48'h0000_0000_0003, 8'h11, 1'b0);
        drain_check("R1 mask clear after reset");

        // R4 latency and first word, with reading held off
        set_ready(1'b0);
        strobe(48'h8C0_000_000_0C1, 8'h5A, 1'b0);
        // the strobe task returned one falling edge after the capture edge
        check(rd_valid == 1'b0, "R4 no word at capture+0", 32'(rd_valid), 32'd0);
        @(negedge clk);
        check(rd_valid == 1'b1, "R4 word at capture+1", 32'(rd_valid), 32'd1);
        check(rd_data == expq[0], "R4 lowest group first", 32'(rd_data), 32'(expq[0]));
        repeat (3) @(negedge clk);
        check(rd_data == expq[0], "R6 data held while not ready", 32'(rd_data), 32'(expq[0]));
        set_ready(1'b1);
        drain_check("R4 R6 drained in order");

        // R3 single hits everywhere produce nothing
        sample(48'h041_041_041_041, 8'h22, 1'b0);
        check(rd_valid == 1'b0, "R3 single hits ignored", 32'(rd_valid), 32'd0);
        drain_check("R3 no words");

        // R2 varied patterns, every group qualifying, ascending order
        sample(48'hFFF_FFF_FFF_FFF, 8'h33, 1'b0);
        sample(48'h30C_A05_003_C30, 8'h44, 1'b0);
        drain_check("R2 varied patterns");

        // R9 external trigger
        sample(48'h000_000_000_018, 8'h55, 1'b1);
        drain_check("R9 trigger sample");

        // R5 mask: suppress pixel 1 and all of group 7
        load_mask(48'hFC0_000_000_002);
        sample(48'hFC0_000_000_003, 8'h66, 1'b0);
        check(rd_valid == 1'b0, "R5 masked pixels drop groups", 32'(rd_valid), 32'd0);
        sample(48'h000_000_000_007, 8'h67, 1'b0);
        drain_check("R5 mask applied");
        // R5 mask_din toggling without mask_load has no effect
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); mask_din = i[0];
        end
        mask_din = 1'b0;
        sample(48'hFC0_000_000_003, 8'h68, 1'b0);
        drain_check("R5 mask held without load");
        load_mask('0);

        // R7 overflow: 24 qualifying groups into 19 slots
        set_ready(1'b0);
        sample(48'hFFF_FFF_FFF_FFF, 8'hA1, 1'b0);
        sample(48'hFFF_FFF_FFF_FFF, 8'hA2, 1'b0);
        check(overflow == 1'b0, "R7 no overflow at 16", 32'(overflow), 32'd0);
        sample(48'hFFF_FFF_FFF_FFF, 8'hA3, 1'b0);
        check(overflow == 1'b1, "R7 overflow set", 32'(overflow), 32'd1);
        repeat (5) @(negedge clk);
        check(overflow == 1'b1, "R7 overflow sticky", 32'(overflow), 32'd1);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        check(overflow == 1'b0, "R7 overflow cleared", 32'(overflow), 32'd0);
        check(expq.size() == DEPTH, "R7 bench queue at depth", 32'(expq.size()), 32'(DEPTH));
        set_ready(1'b1);
        drain_check("R7 stored words intact");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule